// File: doc/BRIEF.md
# Leveled Interrupt Controller with Break

This block gathers level-sensitive interrupt requests from 31 on-chip peripherals and presents one of them to the processor on a single request line. The output carries the winning source's index and its level. Software gives each source one of eight levels through a small write port. One level value switches a source off, and the other seven rank it, with 0 the most urgent. A current mask level filters the requests: only sources whose level is strictly below the mask are forwarded. Requests are also forwarded only while the processor's interrupt-enable input is high.

When the processor accepts the request with an accept pulse, the block latches the source index. It also raises the mask to that source's level, so only more urgent sources can interrupt the handler. Software lowers the priority floor again by writing the mask. A separate, active-low emergency break input is synchronized and edge-detected. A falling edge on it sets a sticky break request that no mask or enable can hold back and that only reset clears. While the break is active, it silences the maskable path.

Top module: `lvl_irq_top`

## Requirements
- R1: After reset, every source level is 7, maskLevel is 7, acceptedSrc is 0, and extIrq and breakReq are low.
- R2: A cycle with cfgWe high writes cfgLevel into the level of source cfgIdx (0..30). A source at level 7 is disabled, and its request never raises extIrq.
- R3: Among eligible requesting sources, the one with the numerically lowest level wins. Level 0 is the most urgent.
- R4: When several eligible requesting sources share the winning level, the lowest source index wins.
- R5: A source is eligible only when its level is strictly below maskLevel. maskLevel 0 blocks every source.
- R6: While intEnable is low, extIrq stays low.
- R7: extIrq, vecNum and vecLevel are registered and reflect the inputs and state present before the previous rising edge. vecNum is the winner's index and vecLevel is its level. Both read 0 when extIrq is low.
- R8: A cycle with ack high while extIrq is high latches vecNum into acceptedSrc and vecLevel into maskLevel. An ack while extIrq is low changes neither.
- R9: A cycle with maskWe high loads maskData into maskLevel. This takes priority over the mask update of R8, while acceptedSrc is still latched.
- R10: A falling edge on breakN passes two synchronizing flip-flops and sets breakReq at the third rising edge after the fall. Holding breakN high sets nothing. breakReq stays high until reset, and intEnable and maskLevel have no effect on it.
- R11: From the edge at which breakReq rises, extIrq stays low, and ack changes neither acceptedSrc nor maskLevel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | 31 | Level request per peripheral source |
| cfgWe | input | 1 | Level write strobe |
| cfgIdx | input | 5 | Source index to write |
| cfgLevel | input | 3 | Level value to write (7 = disabled) |
| maskWe | input | 1 | Mask level write strobe |
| maskData | input | 3 | New mask level |
| intEnable | input | 1 | Processor interrupt-enable state |
| ack | input | 1 | Processor accept pulse |
| breakN | input | 1 | Asynchronous emergency break, falling edge active |
| extIrq | output | 1 | Maskable interrupt request to processor |
| vecNum | output | 5 | Index of the presented source |
| vecLevel | output | 3 | Level of the presented source |
| maskLevel | output | 3 | Current mask level |
| acceptedSrc | output | 5 | Source index latched at the last accept |
| breakReq | output | 1 | Sticky break request |

## Verification
A corrupted level register shows at the ports within one cycle of that source being requested alone. It appears either as a wrong vecLevel or as a missing or spurious extIrq. A broken resolver or tie order shows as a wrong vecNum the cycle after a pattern of competing requests is applied. That is why the bench sweeps every source alone and then runs many overlapping request patterns against an arithmetic model. A mask or accept fault shows on maskLevel and acceptedSrc one edge after ack or maskWe. A break path that is one stage short or long moves the rise of breakReq off the third edge, which the bench pins exactly.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic takeAck;   // accept honoured this cycle
    logic blockIrq;  // break detected or pending: silence maskable path
  } ctlStrobe_t;
endpackage

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lvl_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ack,
  input  logic       extIrq,
  input  logic       breakN,
  output ctlStrobe_t strobe,
  output logic       breakReq
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] brkPipe;
  logic              brkFall;
  logic              breakPend;

  // synchronizer plus one history stage, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) brkPipe <= '1;
    else       brkPipe <= {brkPipe[PIPE_W-2:0], breakN};
  end

  assign brkFall = brkPipe[PIPE_W-1] & ~brkPipe[PIPE_W-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        breakPend <= 1'b0;
    else if (brkFall) breakPend <= 1'b1;
  end

  assign breakReq        = breakPend;
  assign strobe.blockIrq = breakPend | brkFall;
  assign strobe.takeAck  = ack & extIrq & ~strobe.blockIrq;

  // R10: break request is sticky until reset
  a_r10_break_sticky: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |=> breakReq);

  // R11: break silences the maskable request line
  a_r11_break_blocks: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> !extIrq);
endmodule

// File: rtl/lvl_irq_dp.sv
module lvl_irq_dp
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int LVL_W   = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         irqReq,
  input  logic                       cfgWe,
  input  logic [$clog2(NUM_SRC)-1:0] cfgIdx,
  input  logic [LVL_W-1:0]           cfgLevel,
  input  logic                       maskWe,
  input  logic [LVL_W-1:0]           maskData,
  input  logic                       intEnable,
  input  ctlStrobe_t                 strobe,
  output logic                       extIrq,
  output logic [$clog2(NUM_SRC)-1:0] vecNum,
  output logic [LVL_W-1:0]           vecLevel,
  output logic [LVL_W-1:0]           maskLevel,
  output logic [$clog2(NUM_SRC)-1:0] acceptedSrc
);
  localparam int               IDX_W   = $clog2(NUM_SRC);
  localparam logic [LVL_W-1:0] LVL_OFF = '1;

  logic [LVL_W-1:0]   srcLvl [NUM_SRC];
  logic [NUM_SRC-1:0] eligible;
  logic               bestFound;
  logic [IDX_W-1:0]   bestIdx;
  logic [LVL_W-1:0]   bestLvl;
  logic               fire;

  // per-source level registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) srcLvl[i] <= LVL_OFF;
    end else if (cfgWe) begin
      for (int i = 0; i < NUM_SRC; i++)
        if (cfgIdx == IDX_W'(i)) srcLvl[i] <= cfgLevel;
    end
  end

  // eligibility per source
  for (genvar g = 0; g < NUM_SRC; g++) begin : gElig
    assign eligible[g] = irqReq[g] && (srcLvl[g] != LVL_OFF) && (srcLvl[g] < maskLevel);
  end

  // resolver: lowest level wins, scanning downward so lower index wins ties
  always_comb begin
    bestFound = 1'b0;
    bestIdx   = '0;
    bestLvl   = LVL_OFF;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i] && (srcLvl[i] <= bestLvl)) begin
        bestFound = 1'b1;
        bestIdx   = IDX_W'(i);
        bestLvl   = srcLvl[i];
      end
    end
  end

  assign fire = bestFound & intEnable & ~strobe.blockIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extIrq   <= 1'b0;
      vecNum   <= '0;
      vecLevel <= '0;
    end else begin
      extIrq   <= fire;
      vecNum   <= fire ? bestIdx : '0;
      vecLevel <= fire ? bestLvl : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLevel   <= LVL_OFF;
      acceptedSrc <= '0;
    end else begin
      if (maskWe)              maskLevel <= maskData;
      else if (strobe.takeAck) maskLevel <= vecLevel;
      if (strobe.takeAck)      acceptedSrc <= vecNum;
    end
  end

  // R2: a presented request never carries the disabled level
  a_r2_not_disabled: assert property (@(posedge clk) disable iff (!rstN)
    extIrq |-> (vecLevel != LVL_OFF));

  // R5: presented level lay below the mask in force at the sampling edge
  a_r5_below_mask: assert property (@(posedge clk) disable iff (!rstN)
    extIrq |-> (vecLevel < $past(maskLevel)));

  // R6: request only follows a cycle with interrupts enabled
  a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    extIrq |-> $past(intEnable));

  // R8: an honoured accept latches the presented index
  a_r8_accept_latch: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeAck |=> (acceptedSrc == $past(vecNum)));
endmodule

// File: rtl/lvl_irq_top.sv
module lvl_irq_top
  import lvl_irq_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int LVL_W   = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC-1:0]         irqReq,
  input  logic                       cfgWe,
  input  logic [$clog2(NUM_SRC)-1:0] cfgIdx,
  input  logic [LVL_W-1:0]           cfgLevel,
  input  logic                       maskWe,
  input  logic [LVL_W-1:0]           maskData,
  input  logic                       intEnable,
  input  logic                       ack,
  input  logic                       breakN,
  output logic                       extIrq,
  output logic [$clog2(NUM_SRC)-1:0] vecNum,
  output logic [LVL_W-1:0]           vecLevel,
  output logic [LVL_W-1:0]           maskLevel,
  output logic [$clog2(NUM_SRC)-1:0] acceptedSrc,
  output logic                       breakReq
);
  ctlStrobe_t strobe;

  lvl_irq_ctrl #(.SYNC_STAGES(2)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .ack      (ack),
    .extIrq   (extIrq),
    .breakN   (breakN),
    .strobe   (strobe),
    .breakReq (breakReq)
  );

  lvl_irq_dp #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .irqReq      (irqReq),
    .cfgWe       (cfgWe),
    .cfgIdx      (cfgIdx),
    .cfgLevel    (cfgLevel),
    .maskWe      (maskWe),
    .maskData    (maskData),
    .intEnable   (intEnable),
    .strobe      (strobe),
    .extIrq      (extIrq),
    .vecNum      (vecNum),
    .vecLevel    (vecLevel),
    .maskLevel   (maskLevel),
    .acceptedSrc (acceptedSrc)
  );
endmodule

// File: tb/tb_lvl_irq_top.sv
module tb_lvl_irq_top;
  localparam int N = 31;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  irqReq = '0;
  logic          cfgWe = 1'b0;
  logic [4:0]    cfgIdx = '0;
  logic [2:0]    cfgLevel = '0;
  logic          maskWe = 1'b0;
  logic [2:0]    maskData = '0;
  logic          intEnable = 1'b1;
  logic          ack = 1'b0;
  logic          breakN = 1'b1;
  logic          extIrq;
  logic [4:0]    vecNum;
  logic [2:0]    vecLevel;
  logic [2:0]    maskLevel;
  logic [4:0]    acceptedSrc;
  logic          breakReq;

  lvl_irq_top dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .cfgLevel(cfgLevel), .maskWe(maskWe), .maskData(maskData),
    .intEnable(intEnable), .ack(ack), .breakN(breakN), .extIrq(extIrq),
    .vecNum(vecNum), .vecLevel(vecLevel), .maskLevel(maskLevel),
    .acceptedSrc(acceptedSrc), .breakReq(breakReq)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int mLvl [N];
  int mMask, mAcc, curExt, curNum, curLvl;
  bit brkOn;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < N; i++) mLvl[i] = 7;
    mMask = 7; mAcc = 0; curExt = 0; curNum = 0; curLvl = 0; brkOn = 0;
  endtask

  // one clock: predict from inputs held over the edge, then compare at negedge
  task automatic cycle(input string tag);
    int nE, nN, nL;
    nE = 0; nN = 0; nL = 0;
    if (intEnable && !brkOn)
      for (int i = 0; i < N; i++)
        if (irqReq[i] && mLvl[i] < 7 && mLvl[i] < mMask && (nE == 0 || mLvl[i] < nL)) begin
          nE = 1; nN = i; nL = mLvl[i];
        end
    if (ack && curExt != 0 && !brkOn) begin
      mAcc = curNum;
      if (!maskWe) mMask = curLvl;
    end
    if (maskWe) mMask = int'(maskData);
    if (cfgWe) mLvl[cfgIdx] = int'(cfgLevel);
    curExt = nE; curNum = nN; curLvl = nL;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " extIrq"}, int'(extIrq), curExt);
    chk({tag, " vecNum"}, int'(vecNum), curNum);
    chk({tag, " vecLevel"}, int'(vecLevel), curLvl);
    chk({tag, " maskLevel"}, int'(maskLevel), mMask);
    chk({tag, " acceptedSrc"}, int'(acceptedSrc), mAcc);
    cfgWe = 0; maskWe = 0; ack = 0;
  endtask

  task automatic setLvl(input int idx, input int lv);
    cfgWe = 1; cfgIdx = 5'(idx); cfgLevel = 3'(lv);
    cycle("R2 level write");
  endtask

  task automatic setMask(input int m);
    maskWe = 1; maskData = 3'(m);
    cycle("R9 mask write");
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; irqReq = '0; cfgWe = 0; maskWe = 0; ack = 0; intEnable = 1; breakN = 1;
    modelReset();
    repeat (2) @(negedge clk);
    chk("R1 reset extIrq", int'(extIrq), 0);
    chk("R1 reset maskLevel", int'(maskLevel), 7);
    chk("R1 reset acceptedSrc", int'(acceptedSrc), 0);
    chk("R1 reset breakReq", int'(breakReq), 0);
    rstN = 1;
    irqReq = '1;
    cycle("R1 all levels disabled after reset");
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();

    // R7 / R2: every source alone at a computed level
    for (int i = 0; i < N; i++) begin
      setLvl(i, i % 7);
      irqReq = N'(1) << i;
      cycle("R7 single source");
      irqReq = '0;
    end
    // R2: every level value on one source, including disabled
    for (int lv = 0; lv < 8; lv++) begin
      setLvl(5, lv);
      irqReq = N'(1) << 5;
      cycle("R2 level sweep");
      irqReq = '0;
    end

    // R3: mixed levels, many overlapping patterns
    for (int p = 0; p < N; p++) setLvl(p, (p * 3 + 1) % 8);
    for (int k = 0; k < 40; k++) begin
      irqReq = N'((32'h9E3779B9 * (k + 1)) >> (k % 5));
      cycle("R3 lowest level wins");
    end

    // R4: all on one level, lowest index wins
    for (int p = 0; p < N; p++) setLvl(p, 2);
    for (int k = 0; k < N; k++) begin
      irqReq = '1 << k;
      cycle("R4 tie lowest index");
    end

    // R5: mask sweep
    setLvl(9, 0);
    setLvl(20, 5);
    for (int m = 0; m < 8; m++) begin
      setMask(m);
      irqReq = '1;
      cycle("R5 mask filter");
      irqReq = (N'(1) << 20) | (N'(1) << 30);
      cycle("R5 mask filter high levels");
    end

    // R6: interrupt enable gating
    irqReq = '1;
    intEnable = 0;
    cycle("R6 enable low");
    cycle("R6 enable low hold");
    intEnable = 1;
    cycle("R6 enable restored");

    // R8: accept raises mask to the source level
    ack = 1;
    cycle("R8 accept latch");
    cycle("R8 after accept");
    ack = 1;
    cycle("R8 accept while idle ignored");
    // R9: mask write wins over accept's mask update
    setMask(7);
    cycle("R9 request back");
    maskWe = 1; maskData = 3'd4; ack = 1;
    cycle("R9 mask write beats accept");
    setMask(7);
    irqReq = N'(1) << 20;
    cycle("R8 second source");
    ack = 1;
    cycle("R8 accept level five");

    // R10 / R11: break edge timing, stickiness and precedence
    setMask(7);
    irqReq = '1;
    for (int c = 0; c < 3; c++) begin
      cycle("R10 idle high no break");
      chk("R10 idle high breakReq", int'(breakReq), 0);
    end
    breakN = 0;
    cycle("R10 sync stage 1");
    chk("R10 breakReq after one edge", int'(breakReq), 0);
    cycle("R10 sync stage 2");
    chk("R10 breakReq after two edges", int'(breakReq), 0);
    brkOn = 1;
    cycle("R11 break blocks request");
    chk("R10 breakReq at third edge", int'(breakReq), 1);
    ack = 1;
    cycle("R11 accept ignored during break");
    breakN = 1;
    cycle("R10 break release");
    intEnable = 0;
    cycle("R10 sticky");
    chk("R10 breakReq sticky", int'(breakReq), 1);

    // R10: break independent of enable and mask
    doReset();
    intEnable = 0;
    setMask(0);
    breakN = 0;
    cycle("R10 break no enable 1");
    cycle("R10 break no enable 2");
    brkOn = 1;
    cycle("R10 break no enable 3");
    chk("R10 breakReq with enable low", int'(breakReq), 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule